// File: doc/BRIEF.md
# Prioritized Interrupt Vector Controller

This block sits beside a small CPU core and decides which interrupt the core should service next. It collects three kinds of requests. Reset requests come from power-up, an external reset line, a watchdog timeout, a flash key violation or an illegal instruction fetch. Non-maskable requests each have their own enable bit. Maskable requests are grouped so that several flags share one vector. Each cycle the block picks the most urgent pending request and presents the word address of its vector slot, together with a request strobe.

When the core accepts the request, the block latches the chosen vector address and pulses an acknowledge for one cycle. Accepting a maskable or reset request clears the global interrupt enable that the block holds; the handler is expected to re-enable it. The block never clears peripheral flags, so a flag stays pending until its owner clears it.

The block also checks two things. The core reports the word it read from the reset slot, and if that word is the erased pattern the block raises a halt output for the low-power logic. Fetch addresses inside the peripheral register window or a configurable unused window raise a reset request.

Top module: `irq_vector_ctrl`

## Requirements
- R1: The vector address is 0xFFC0 + 2*level. Reset is level 31 (0xFFFE), non-maskable is level 30 (0xFFFC), and maskable group i is level 29-i. No request ever selects levels 15..0 (addresses below 0xFFE0).
- R2: After rst_n is released a reset request is pending. While a reset request is pending, irq_req is 1, the address is 0xFFFE and irq_class is 2'b11, whatever other requests exist.
- R3: Any of por_req, ext_rst_req, wdt_rst_req or key_viol_req high at a clock edge makes a reset request pending from the next cycle.
- R4: A non-maskable source k requests level 30 (irq_class 2'b10) when nmi_flag[k] and nmi_en[k] are both 1, independent of gie. A flag whose enable is 0 has no effect.
- R5: A maskable group requests only when gie is 1. With gie at 0, irq_req stays 0 if no reset or non-maskable request is pending. irq_class is 2'b01 for a maskable selection and 2'b00 when nothing is requested.
- R6: Group i is pending while any bit j satisfies mask_flag[i*FPV+j] and mask_en[i*FPV+j]. The block does not clear flags, so an accepted group requests again once gie returns to 1.
- R7: The order is reset, then non-maskable, then the maskable group with the lowest index.
- R8: When cpu_accept and irq_req are 1 at an edge, irq_ack is 1 for exactly the following cycle, and ack_vec_addr holds the address selected at that edge.
- R9: gie_wr loads gie from gie_wdata at the edge. Accepting a maskable or reset request clears gie at the edge, and this takes precedence over a write in the same cycle. Accepting a non-maskable request leaves gie unchanged.
- R10: rstvec_valid with rstvec_data = 0xFFFF sets halt_lpm from the next cycle. Any other word does not set it. halt_lpm stays set until rst_n or the acceptance of a reset request.
- R11: fetch_valid with fetch_addr below 0x0200, or inside [ILL_LO, ILL_HI] (default 0x0A00..0x0FFF), makes a reset request pending from the next cycle. Other addresses do not.
- R12: Accepting a reset request clears it, unless a reset source is active in the same cycle, in which case it stays pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| por_req | input | 1 | Power-up reset source |
| ext_rst_req | input | 1 | External reset line source |
| wdt_rst_req | input | 1 | Watchdog timeout source |
| key_viol_req | input | 1 | Flash key violation source |
| fetch_valid | input | 1 | Instruction fetch address valid |
| fetch_addr | input | 16 | Instruction fetch address |
| rstvec_valid | input | 1 | Reset slot word valid |
| rstvec_data | input | 16 | Word read from the reset slot |
| nmi_flag | input | NMI_SRC | Non-maskable source flags |
| nmi_en | input | NMI_SRC | Non-maskable source enables |
| mask_flag | input | NUM_MASK*FPV | Maskable flags, FPV per group |
| mask_en | input | NUM_MASK*FPV | Maskable enables |
| gie_wr | input | 1 | Write strobe for the global enable |
| gie_wdata | input | 1 | Value for the global enable |
| cpu_accept | input | 1 | Core accepts the current request |
| irq_req | output | 1 | A request is selected |
| irq_vec_addr | output | 16 | Vector slot address of the selection |
| irq_level | output | 5 | Priority level of the selection |
| irq_class | output | 2 | 00 none, 01 maskable, 10 non-maskable, 11 reset |
| irq_ack | output | 1 | One-cycle acknowledge after acceptance |
| ack_vec_addr | output | 16 | Vector address latched at acceptance |
| gie | output | 1 | Global interrupt enable |
| halt_lpm | output | 1 | Erased reset slot detected |

## Verification
The bench builds the block with NUM_MASK = 14, FPV = 4 and NMI_SRC = 3. With these values all fourteen maskable levels down to 16 (address 0xFFE0) are present, so the lowest slot next to the reserved region can be reached. Groups with four flags each show both sharing and per-bit enable gating. Random flag, enable and global-enable patterns are compared against a separate priority model. Directed cases cover acceptance, the edges of the illegal fetch windows, and a reset source active in the same cycle as acceptance.

// File: rtl/irqv_pkg.sv
// Package: shared constants, class encoding and level-to-address mapping
// for the interrupt vector controller. Assumes a 16-bit word address space.
package irqv_pkg;

    localparam int                 LVL_W        = 5;
    localparam int                 ADDR_W       = 16;
    localparam logic [ADDR_W-1:0]  VEC_BASE     = 16'hFFC0;
    localparam logic [LVL_W-1:0]   LVL_RESET    = 5'd31;
    localparam logic [LVL_W-1:0]   LVL_NMI      = 5'd30;
    localparam int                 LVL_MASK_TOP = 29;

    typedef enum logic [1:0] {
        CLS_NONE  = 2'b00,
        CLS_MASK  = 2'b01,
        CLS_NMI   = 2'b10,
        CLS_RESET = 2'b11
    } irq_class_e;

    // Map a priority level to the word address of its vector slot.
    function automatic logic [ADDR_W-1:0] level_to_addr(input logic [LVL_W-1:0] lvl);
        return VEC_BASE + {10'd0, lvl, 1'b0};
    endfunction

endpackage

// File: rtl/irqv_group_or.sv
// Module: reduces per-flag requests to one pending bit per maskable vector
// and one combined non-maskable pending bit.
// Assumes flags of group g occupy bits [g*FPV +: FPV]. Purely combinational.
module irqv_group_or #(
    parameter int NUM_MASK = 14,
    parameter int FPV      = 8,
    parameter int NMI_SRC  = 3,
    localparam int MW      = NUM_MASK * FPV
) (
    input  logic [MW-1:0]       mask_flag,
    input  logic [MW-1:0]       mask_en,
    input  logic [NMI_SRC-1:0]  nmi_flag,
    input  logic [NMI_SRC-1:0]  nmi_en,
    output logic [NUM_MASK-1:0] grp_pend,
    output logic                nmi_pend
);

    // One OR-reduction per shared vector.
    for (genvar g = 0; g < NUM_MASK; g++) begin : g_grp
        assign grp_pend[g] = |(mask_flag[g*FPV +: FPV] & mask_en[g*FPV +: FPV]);
    end

    // Non-maskable sources are gated only by their own enables.
    assign nmi_pend = |(nmi_flag & nmi_en);

endmodule

// File: rtl/irqv_prio_enc.sv
// Module: picks the most urgent request: reset, then non-maskable, then the
// lowest-index maskable group, the latter only with the global enable set.
// Assumes NUM_MASK <= 14 so no maskable level falls below 16. Combinational.
module irqv_prio_enc
    import irqv_pkg::*;
#(
    parameter int NUM_MASK = 14
) (
    input  logic                reset_pend,
    input  logic                nmi_pend,
    input  logic [NUM_MASK-1:0] grp_pend,
    input  logic                gie,
    output logic                sel_req,
    output logic [LVL_W-1:0]    sel_level,
    output logic [ADDR_W-1:0]   sel_addr,
    output irq_class_e          sel_class
);

    logic             mask_hit;
    logic [LVL_W-1:0] mask_lvl;

    // Scan from lowest to highest priority so the highest pending group wins.
    always_comb begin
        mask_hit = 1'b0;
        mask_lvl = '0;
        for (int i = NUM_MASK - 1; i >= 0; i--) begin
            if (grp_pend[i]) begin
                mask_hit = 1'b1;
                mask_lvl = LVL_W'(LVL_MASK_TOP - i);
            end
        end
    end

    // Class arbitration between reset, non-maskable and gated maskable requests.
    always_comb begin
        sel_req   = 1'b1;
        sel_level = '0;
        sel_class = CLS_NONE;
        if (reset_pend) begin
            sel_level = LVL_RESET;
            sel_class = CLS_RESET;
        end else if (nmi_pend) begin
            sel_level = LVL_NMI;
            sel_class = CLS_NMI;
        end else if (gie && mask_hit) begin
            sel_level = mask_lvl;
            sel_class = CLS_MASK;
        end else begin
            sel_req = 1'b0;
        end
    end

    // Slot address follows from the level; zero when nothing is selected.
    assign sel_addr = sel_req ? level_to_addr(sel_level) : '0;

endmodule

// File: rtl/irqv_reset_ctl.sv
// Module: holds the pending reset request and the erased-slot halt flag,
// and detects instruction fetches from the register or unused windows.
// Assumes reset sources are level inputs sampled each cycle; sync active-low reset.
module irqv_reset_ctl #(
    parameter logic [15:0] REG_TOP = 16'h0200,
    parameter logic [15:0] ILL_LO  = 16'h0A00,
    parameter logic [15:0] ILL_HI  = 16'h0FFF,
    parameter logic [15:0] ERASED  = 16'hFFFF
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        por_req,
    input  logic        ext_rst_req,
    input  logic        wdt_rst_req,
    input  logic        key_viol_req,
    input  logic        fetch_valid,
    input  logic [15:0] fetch_addr,
    input  logic        rstvec_valid,
    input  logic [15:0] rstvec_data,
    input  logic        rst_taken,
    output logic        reset_pend,
    output logic        halt
);

    logic bad_fetch;
    logic any_src;
    logic erased_seen;

    // Flag fetches that land in the register window or the unused window.
    always_comb begin
        bad_fetch = fetch_valid &&
                    ((fetch_addr < REG_TOP) ||
                     ((fetch_addr >= ILL_LO) && (fetch_addr <= ILL_HI)));
    end

    assign any_src     = por_req | ext_rst_req | wdt_rst_req | key_viol_req | bad_fetch;
    assign erased_seen = rstvec_valid && (rstvec_data == ERASED);

    // Reset request: pending out of reset, set by any source, cleared on acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n)         reset_pend <= 1'b1;
        else if (any_src)   reset_pend <= 1'b1;
        else if (rst_taken) reset_pend <= 1'b0;
    end

    // Halt flag: set on an erased reset slot, released by the next reset acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n)           halt <= 1'b0;
        else if (erased_seen) halt <= 1'b1;
        else if (rst_taken)   halt <= 1'b0;
    end

    AST_SRC_SETS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
        (por_req || ext_rst_req || wdt_rst_req || key_viol_req) |=> reset_pend); // R3
    AST_LOW_FETCH_RST: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_valid && fetch_addr < REG_TOP) |=> reset_pend); // R11
    AST_ERASED_HALT: assert property (@(posedge clk) disable iff (!rst_n)
        (rstvec_valid && rstvec_data == 16'hFFFF) |=> halt); // R10
    AST_TAKE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_taken && !any_src) |=> !reset_pend); // R12

endmodule

// File: rtl/irq_vector_ctrl.sv
// Module: top of the interrupt vector controller. Combines the reset,
// non-maskable and maskable requests, keeps the global enable, and latches
// the accepted vector with a one-cycle acknowledge.
// Assumes the core asserts cpu_accept only while it can take the request.
module irq_vector_ctrl
    import irqv_pkg::*;
#(
    parameter int          NUM_MASK = 14,
    parameter int          FPV      = 8,
    parameter int          NMI_SRC  = 3,
    parameter logic [15:0] ILL_LO   = 16'h0A00,
    parameter logic [15:0] ILL_HI   = 16'h0FFF,
    localparam int         MW       = NUM_MASK * FPV
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               por_req,
    input  logic               ext_rst_req,
    input  logic               wdt_rst_req,
    input  logic               key_viol_req,
    input  logic               fetch_valid,
    input  logic [15:0]        fetch_addr,
    input  logic               rstvec_valid,
    input  logic [15:0]        rstvec_data,
    input  logic [NMI_SRC-1:0] nmi_flag,
    input  logic [NMI_SRC-1:0] nmi_en,
    input  logic [MW-1:0]      mask_flag,
    input  logic [MW-1:0]      mask_en,
    input  logic               gie_wr,
    input  logic               gie_wdata,
    input  logic               cpu_accept,
    output logic               irq_req,
    output logic [15:0]        irq_vec_addr,
    output logic [4:0]         irq_level,
    output logic [1:0]         irq_class,
    output logic               irq_ack,
    output logic [15:0]        ack_vec_addr,
    output logic               gie,
    output logic               halt_lpm
);

    logic [NUM_MASK-1:0] grp_pend;
    logic                nmi_pend;
    logic                reset_pend;
    logic                take;
    logic                rst_taken;
    irq_class_e          sel_class;

    irqv_group_or #(
        .NUM_MASK (NUM_MASK),
        .FPV      (FPV),
        .NMI_SRC  (NMI_SRC)
    ) u_grp (
        .mask_flag (mask_flag),
        .mask_en   (mask_en),
        .nmi_flag  (nmi_flag),
        .nmi_en    (nmi_en),
        .grp_pend  (grp_pend),
        .nmi_pend  (nmi_pend)
    );

    irqv_reset_ctl #(
        .ILL_LO (ILL_LO),
        .ILL_HI (ILL_HI)
    ) u_rst (
        .clk          (clk),
        .rst_n        (rst_n),
        .por_req      (por_req),
        .ext_rst_req  (ext_rst_req),
        .wdt_rst_req  (wdt_rst_req),
        .key_viol_req (key_viol_req),
        .fetch_valid  (fetch_valid),
        .fetch_addr   (fetch_addr),
        .rstvec_valid (rstvec_valid),
        .rstvec_data  (rstvec_data),
        .rst_taken    (rst_taken),
        .reset_pend   (reset_pend),
        .halt         (halt_lpm)
    );

    irqv_prio_enc #(
        .NUM_MASK (NUM_MASK)
    ) u_prio (
        .reset_pend (reset_pend),
        .nmi_pend   (nmi_pend),
        .grp_pend   (grp_pend),
        .gie        (gie),
        .sel_req    (irq_req),
        .sel_level  (irq_level),
        .sel_addr   (irq_vec_addr),
        .sel_class  (sel_class)
    );

    assign irq_class = sel_class;
    assign take      = cpu_accept && irq_req;
    assign rst_taken = take && (sel_class == CLS_RESET);

    // Global enable: cleared on maskable or reset acceptance, otherwise loaded by writes.
    always_ff @(posedge clk) begin
        if (!rst_n)
            gie <= 1'b0;
        else if (take && (sel_class == CLS_MASK || sel_class == CLS_RESET))
            gie <= 1'b0;
        else if (gie_wr)
            gie <= gie_wdata;
    end

    // Acknowledge pulse and vector latch on acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_ack      <= 1'b0;
            ack_vec_addr <= '0;
        end else begin
            irq_ack <= take;
            if (take) ack_vec_addr <= irq_vec_addr;
        end
    end

    AST_NO_RESERVED_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> (irq_vec_addr >= 16'hFFE0)); // R1
    AST_RESET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        reset_pend |-> (irq_req && irq_vec_addr == 16'hFFFE)); // R2
    AST_NMI_SERVED: assert property (@(posedge clk) disable iff (!rst_n)
        (nmi_pend && !reset_pend) |-> (irq_req && irq_vec_addr == 16'hFFFC)); // R4
    AST_MASK_NEEDS_GIE: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_req && irq_class == 2'b01) |-> gie); // R5
    AST_ACK_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> (irq_ack && ack_vec_addr == $past(irq_vec_addr))); // R8
    AST_GIE_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (take && irq_class == 2'b01) |=> !gie); // R9

endmodule

// File: tb/tb_irq_vector_ctrl.sv
module tb_irq_vector_ctrl;

    localparam int NM  = 14;
    localparam int FP  = 4;
    localparam int NS  = 3;
    localparam int MW  = NM * FP;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          por_req, ext_rst_req, wdt_rst_req, key_viol_req;
    logic          fetch_valid;
    logic [15:0]   fetch_addr;
    logic          rstvec_valid;
    logic [15:0]   rstvec_data;
    logic [NS-1:0] nmi_flag, nmi_en;
    logic [MW-1:0] mask_flag, mask_en;
    logic          gie_wr, gie_wdata, cpu_accept;
    logic          irq_req, irq_ack, gie, halt_lpm;
    logic [15:0]   irq_vec_addr, ack_vec_addr;
    logic [4:0]    irq_level;
    logic [1:0]    irq_class;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 0;

    always #4 clk = ~clk;

    irq_vector_ctrl #(.NUM_MASK(NM), .FPV(FP), .NMI_SRC(NS)) dut (
        .clk(clk), .rst_n(rst_n), .por_req(por_req), .ext_rst_req(ext_rst_req),
        .wdt_rst_req(wdt_rst_req), .key_viol_req(key_viol_req),
        .fetch_valid(fetch_valid), .fetch_addr(fetch_addr),
        .rstvec_valid(rstvec_valid), .rstvec_data(rstvec_data),
        .nmi_flag(nmi_flag), .nmi_en(nmi_en), .mask_flag(mask_flag), .mask_en(mask_en),
        .gie_wr(gie_wr), .gie_wdata(gie_wdata), .cpu_accept(cpu_accept),
        .irq_req(irq_req), .irq_vec_addr(irq_vec_addr), .irq_level(irq_level),
        .irq_class(irq_class), .irq_ack(irq_ack), .ack_vec_addr(ack_vec_addr),
        .gie(gie), .halt_lpm(halt_lpm)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    // Advance one edge; land 2 ns after it so registered outputs are settled.
    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    // Reference priority model: returns {req, addr}.
    function automatic logic [16:0] model(input logic rp, input logic [NS-1:0] nf,
                                          input logic [NS-1:0] ne, input logic [MW-1:0] f,
                                          input logic [MW-1:0] e, input logic g);
        if (rp) return {1'b1, 16'hFFFE};
        if ((nf & ne) != '0) return {1'b1, 16'hFFFC};
        if (g) begin
            for (int i = 0; i < NM; i++) begin
                if ((f[i*FP +: FP] & e[i*FP +: FP]) != '0)
                    return {1'b1, 16'(16'hFFFA - 2*i)};
            end
        end
        return 17'd0;
    endfunction

    task automatic idle_inputs();
        por_req = 0; ext_rst_req = 0; wdt_rst_req = 0; key_viol_req = 0;
        fetch_valid = 0; fetch_addr = 16'hC000; rstvec_valid = 0; rstvec_data = 0;
        nmi_flag = '0; nmi_en = '0; mask_flag = '0; mask_en = '0;
        gie_wr = 0; gie_wdata = 0; cpu_accept = 0;
    endtask

    task automatic accept_once();
        cpu_accept = 1; tick(); cpu_accept = 0;
    endtask

    task automatic set_gie(input logic v);
        gie_wr = 1; gie_wdata = v; tick(); gie_wr = 0;
    endtask

    task automatic t_reset_state();
        chk("R2 req after reset", 32'(irq_req), 1);
        chk("R2 addr after reset", 32'(irq_vec_addr), 32'hFFFE);
        chk("R2 class reset", 32'(irq_class), 3);
        chk("R1 level reset", 32'(irq_level), 31);
        chk("R9 gie after reset", 32'(gie), 0);
        chk("R10 halt after reset", 32'(halt_lpm), 0);
        chk("R8 ack idle", 32'(irq_ack), 0);
        nmi_flag = 3'b111; nmi_en = 3'b111; #1;
        chk("R7 reset over nmi", 32'(irq_vec_addr), 32'hFFFE);
        nmi_flag = '0; nmi_en = '0;
        accept_once();
        chk("R8 ack after reset accept", 32'(irq_ack), 1);
        chk("R8 ack vec reset", 32'(ack_vec_addr), 32'hFFFE);
        chk("R12 reset cleared", 32'(irq_req), 0);
        chk("R5 class none", 32'(irq_class), 0);
        tick();
        chk("R8 ack one cycle", 32'(irq_ack), 0);
    endtask

    task automatic t_nmi();
        nmi_flag = 3'b010; nmi_en = 3'b101; #1;
        chk("R4 disabled nmi ignored", 32'(irq_req), 0);
        nmi_en = 3'b010; #1;
        chk("R4 nmi without gie", 32'(irq_req), 1);
        chk("R4 nmi addr", 32'(irq_vec_addr), 32'hFFFC);
        chk("R4 nmi class", 32'(irq_class), 2);
        set_gie(1);
        accept_once();
        chk("R8 ack vec nmi", 32'(ack_vec_addr), 32'hFFFC);
        chk("R9 gie kept on nmi accept", 32'(gie), 1);
        nmi_flag = '0; nmi_en = '0;
        set_gie(0);
    endtask

    task automatic t_mask_gate();
        mask_flag[3*FP] = 1; mask_en[3*FP] = 1; #1;
        chk("R5 masked without gie", 32'(irq_req), 0);
        set_gie(1);
        chk("R5 maskable with gie", 32'(irq_vec_addr), 32'hFFF4);
        chk("R1 level group3", 32'(irq_level), 26);
        chk("R5 class maskable", 32'(irq_class), 1);
        mask_flag[13*FP+2] = 1; mask_en[13*FP+2] = 1;
        mask_flag[3*FP] = 0; #1;
        chk("R1 lowest slot", 32'(irq_vec_addr), 32'hFFE0);
        chk("R1 lowest level", 32'(irq_level), 16);
        mask_flag[5*FP+1] = 1; mask_en[5*FP+1] = 1; #1;
        chk("R7 lower index wins", 32'(irq_vec_addr), 32'hFFF0);
        nmi_flag[0] = 1; nmi_en[0] = 1; #1;
        chk("R7 nmi over maskable", 32'(irq_vec_addr), 32'hFFFC);
        nmi_flag = '0; nmi_en = '0; mask_flag = '0; mask_en = '0;
        set_gie(0);
    endtask

    task automatic t_shared_accept();
        mask_flag[7*FP+3] = 1; mask_en[7*FP+3] = 0;
        set_gie(1);
        chk("R6 disabled flag in group", 32'(irq_req), 0);
        mask_flag[7*FP+1] = 1; mask_en[7*FP+1] = 1; #1;
        chk("R6 shared vector", 32'(irq_vec_addr), 32'hFFEC);
        gie_wr = 1; gie_wdata = 1;
        accept_once();
        gie_wr = 0;
        chk("R8 ack maskable", 32'(irq_ack), 1);
        chk("R8 ack vec maskable", 32'(ack_vec_addr), 32'hFFEC);
        chk("R9 clear beats write", 32'(gie), 0);
        chk("R5 dropped with gie off", 32'(irq_req), 0);
        set_gie(1);
        chk("R6 flag not cleared", 32'(irq_vec_addr), 32'hFFEC);
        mask_flag = '0; mask_en = '0;
        set_gie(0);
    endtask

    task automatic t_sources();
        for (int s = 0; s < 4; s++) begin
            por_req = (s == 0); ext_rst_req = (s == 1);
            wdt_rst_req = (s == 2); key_viol_req = (s == 3);
            tick();
            por_req = 0; ext_rst_req = 0; wdt_rst_req = 0; key_viol_req = 0;
            chk("R3 source sets reset", 32'(irq_vec_addr), 32'hFFFE);
            accept_once();
            chk("R12 cleared after accept", 32'(irq_req), 0);
        end
        wdt_rst_req = 1;
        accept_once();
        wdt_rst_req = 0;
        chk("R12 set wins over clear", 32'(irq_vec_addr), 32'hFFFE);
        accept_once();
        chk("R12 clear after set", 32'(irq_req), 0);
    endtask

    task automatic fetch_case(input logic [15:0] a, input logic bad);
        fetch_valid = 1; fetch_addr = a; tick(); fetch_valid = 0;
        chk("R11 fetch window", 32'(irq_req), 32'(bad));
        if (bad) accept_once();
    endtask

    task automatic t_fetch();
        fetch_case(16'h01FE, 1);
        fetch_case(16'h0000, 1);
        fetch_case(16'h0200, 0);
        fetch_case(16'h09FE, 0);
        fetch_case(16'h0A00, 1);
        fetch_case(16'h0FFF, 1);
        fetch_case(16'h1000, 0);
        fetch_addr = 16'h0100; tick();
        chk("R11 fetch without valid", 32'(irq_req), 0);
    endtask

    task automatic t_halt();
        rstvec_valid = 1; rstvec_data = 16'hF000; tick(); rstvec_valid = 0;
        chk("R10 programmed slot", 32'(halt_lpm), 0);
        rstvec_valid = 1; rstvec_data = 16'hFFFF; tick(); rstvec_valid = 0;
        chk("R10 erased slot halts", 32'(halt_lpm), 1);
        tick();
        chk("R10 halt sticky", 32'(halt_lpm), 1);
        ext_rst_req = 1; tick(); ext_rst_req = 0;
        accept_once();
        chk("R10 halt released on reset", 32'(halt_lpm), 0);
    endtask

    task automatic t_random();
        for (int k = 0; k < 400; k++) begin
            logic g;
            logic [16:0] e;
            g = 1'($urandom());
            set_gie(g);
            mask_flag = MW'({$urandom(), $urandom()} & {$urandom(), $urandom()});
            mask_en   = MW'({$urandom(), $urandom()} & {$urandom(), $urandom()});
            if (($urandom() % 4) == 0) begin
                nmi_flag = NS'($urandom()); nmi_en = NS'($urandom());
            end else begin
                nmi_flag = '0; nmi_en = '0;
            end
            #1;
            e = model(1'b0, nmi_flag, nmi_en, mask_flag, mask_en, g);
            chk("R7 random req", 32'(irq_req), 32'(e[16]));
            chk("R7 random addr", 32'(irq_vec_addr), 32'(e[15:0]));
        end
        mask_flag = '0; mask_en = '0; nmi_flag = '0; nmi_en = '0;
        set_gie(0);
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        idle_inputs();
        rst_n = 0;
        tick(); tick(); tick();
        rst_n = 1;
        tick();
        t_reset_state();
        t_nmi();
        t_mask_gate();
        t_shared_accept();
        t_sources();
        t_fetch();
        t_halt();
        t_random();
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule